// File: doc/BRIEF.md
# Vector Mask Compare and Merge Unit

This block is the condition engine of a vector pipeline. It holds a per-element mask and a vector length, and it runs one of three element-serial operations. A compare pass fills the mask from the equality of two source vectors. A merge pass writes result elements back to a destination register only where the mask allows. A compress pass packs the allowed results into the lowest destination slots. The sequencer walks one element per clock from element 0 up to the vector length. It presents the element number on `el_idx` so that the surrounding register file can supply that element's operands in the same cycle.

Software can also load the mask and the vector length directly from scalar values while the unit is idle. Destination writes leave the block as a per-element write strobe with an index and data. Slots that are not strobed keep whatever they held. A masked-off element still takes its full clock slot, so the run time depends only on the vector length.

Top module: `vmask_unit`

## Requirements
- R1: After reset `busy`, `fin` and `dst_we` are 0, `mask_q` is all zeros and `vl_q` equals MVL (64).
- R2: A `vl_we` pulse while idle loads `vl_q` from `vl_din`, and values above MVL are clamped to MVL. While busy, `vl_we` is ignored. When it coincides with an accepted `go`, that operation runs with the previous length and `vl_q` takes the new value.
- R3: A `mk_we` pulse while idle loads `mask_q` from `mk_din`, and it is ignored while busy. When it coincides with a merge or compress launch, that operation already uses the new mask.
- R4: A compare (`go_op` = 0) sets mask bit i to 1 exactly when `src_a` equals `src_b` for element i, for every i below the length. It clears every bit at or above the length. A scalar mask write in its launch cycle loses to the compare.
- R5: A merge (`go_op` = 1) raises `dst_we` for element i only if mask bit i is 1 and i is below the length, with `dst_idx` = i and `dst_dat` = the `res_in` value presented for element i.
- R6: Elements whose mask bit is 0 produce no destination write, so those destination slots keep their previous contents.
- R7: A compress (`go_op` = 2) writes the k-th enabled element (counting from 0 in element order) to `dst_idx` = k.
- R8: At the `fin` pulse, `pack_cnt` equals the number of destination writes made by the merge or compress that just ended.
- R9: Elements are handled one per clock whatever their mask bit. Relative to the edge that accepts `go`, `fin` is high for one cycle after edge VL+1. For a length of zero this is after the next edge.
- R10: `go` is ignored while busy, and `go_op` = 3 is never accepted: neither changes the mask, the length or the running operation.
- R11: With a length of zero, an operation makes no destination write, and a compare clears the whole mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vl_we | input | 1 | Load vector length from scalar |
| vl_din | input | LW (7) | Scalar vector length value |
| mk_we | input | 1 | Load mask from scalar |
| mk_din | input | MVL (64) | Scalar mask value, bit i for element i |
| go | input | 1 | Start an operation |
| go_op | input | 2 | 0 compare, 1 merge, 2 compress, 3 rejected |
| busy | output | 1 | Elements being walked |
| el_idx | output | IW (6) | Element being handled this cycle |
| src_a | input | EW (32) | First compare operand for `el_idx` |
| src_b | input | EW (32) | Second compare operand for `el_idx` |
| res_in | input | EW (32) | Result element for `el_idx` |
| dst_we | output | 1 | Destination element write strobe |
| dst_idx | output | IW (6) | Destination element index |
| dst_dat | output | EW (32) | Destination element data |
| fin | output | 1 | One-cycle end-of-operation pulse |
| pack_cnt | output | LW (7) | Elements written by the last merge/compress |
| mask_q | output | MVL (64) | Current mask register |
| vl_q | output | LW (7) | Current vector length register |

## Verification
Two functions can coincide in one cycle: a scalar write to the mask or the length, and the launch of an operation that reads or writes that same register. The bench provokes both cases. It drives `mk_we` in the launch cycle of a compare, where the compare result must win, and in the launch cycle of a merge, where the merge must already use the new mask. It also drives `vl_we` together with `go`, where the run length must be the old value and `vl_q` the new one. In the middle of a run it drives writes and a second `go` together, and the resulting mask, length, latency and destination image show that all of them were ignored.

// File: rtl/vmcm_pkg.sv
package vmcm_pkg;

   // Operation codes carried on go_op
   typedef enum logic [1:0] {
      OP_CMP  = 2'd0,
      OP_MRG  = 2'd1,
      OP_CPR  = 2'd2,
      OP_NONE = 2'd3
   } vop_e;

endpackage

// File: rtl/vmcm_seq.sv
module vmcm_seq
   import vmcm_pkg::*;
#(
   parameter int MVL = 64,
   localparam int IW = $clog2(MVL),
   localparam int LW = $clog2(MVL + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  vop_e          go_op,
   input  logic [LW-1:0] vl_q,
   output logic          launch,
   output logic          busy,
   output logic [IW-1:0] idx,
   output vop_e          op_q,
   output logic          fin
);

   logic [LW-1:0] vl_s;
   logic          last;

   assign launch = go && !busy && (go_op != OP_NONE);
   assign last   = busy && ((LW'(idx) + LW'(1)) == vl_s);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         op_q <= OP_MRG;
         fin  <= 1'b0;
         vl_s <= '0;
      end else begin
         fin <= 1'b0;
         if (launch) begin
            op_q <= go_op;
            idx  <= '0;
            vl_s <= vl_q;
            if (vl_q == '0) fin  <= 1'b1;
            else            busy <= 1'b1;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               fin  <= 1'b1;
               idx  <= '0;
            end else begin
               idx <= idx + IW'(1);
            end
         end
      end
   end

endmodule

// File: rtl/vmcm_mask.sv
module vmcm_mask
   import vmcm_pkg::*;
#(
   parameter int MVL = 64,
   parameter int EW  = 32,
   localparam int IW = $clog2(MVL)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mk_we,
   input  logic [MVL-1:0] mk_din,
   input  logic           busy,
   input  logic           launch,
   input  vop_e           go_op,
   input  vop_e           op_q,
   input  logic [IW-1:0]  idx,
   input  logic [EW-1:0]  src_a,
   input  logic [EW-1:0]  src_b,
   output logic [MVL-1:0] mask_q
);

   logic cmp_clr, cmp_step, hit, scal_wr;

   assign cmp_clr  = launch && (go_op == OP_CMP);
   assign cmp_step = busy && (op_q == OP_CMP);
   assign hit      = (src_a == src_b);
   assign scal_wr  = mk_we && !busy;

   for (genvar g = 0; g < MVL; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[g] <= 1'b0;
         else if (cmp_clr)
            mask_q[g] <= 1'b0;
         else if (cmp_step && (idx == IW'(g)))
            mask_q[g] <= hit;
         else if (scal_wr)
            mask_q[g] <= mk_din[g];
      end
   end

endmodule

// File: rtl/vmcm_wb.sv
module vmcm_wb
   import vmcm_pkg::*;
#(
   parameter int MVL       = 64,
   parameter int EW        = 32,
   parameter bit IDLE_ZERO = 1'b0,
   localparam int IW = $clog2(MVL),
   localparam int LW = $clog2(MVL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           launch,
   input  logic           busy,
   input  vop_e           op_q,
   input  logic [IW-1:0]  idx,
   input  logic [MVL-1:0] mask_q,
   input  logic [EW-1:0]  res_in,
   output logic           dst_we,
   output logic [IW-1:0]  dst_idx,
   output logic [EW-1:0]  dst_dat,
   output logic [LW-1:0]  cnt
);

   logic en, packing;

   assign packing = (op_q == OP_CPR);
   assign en      = busy && (op_q != OP_CMP) && mask_q[idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_we  <= 1'b0;
         dst_idx <= '0;
         cnt     <= '0;
      end else begin
         dst_we <= en;
         if (launch) begin
            cnt <= '0;
         end else if (en) begin
            dst_idx <= packing ? cnt[IW-1:0] : idx;
            cnt     <= cnt + LW'(1);
         end
      end
   end

   if (IDLE_ZERO) begin : g_dat_zero
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   dst_dat <= '0;
         else if (en)  dst_dat <= res_in;
         else          dst_dat <= '0;
      end
   end else begin : g_dat_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   dst_dat <= '0;
         else if (en)  dst_dat <= res_in;
      end
   end

endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
   import vmcm_pkg::*;
#(
   parameter int EW        = 32,
   parameter int MVL       = 64,
   parameter bit IDLE_ZERO = 1'b0,
   localparam int IW = $clog2(MVL),
   localparam int LW = $clog2(MVL + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           vl_we,
   input  logic [LW-1:0]  vl_din,
   input  logic           mk_we,
   input  logic [MVL-1:0] mk_din,
   input  logic           go,
   input  logic [1:0]     go_op,
   output logic           busy,
   output logic [IW-1:0]  el_idx,
   input  logic [EW-1:0]  src_a,
   input  logic [EW-1:0]  src_b,
   input  logic [EW-1:0]  res_in,
   output logic           dst_we,
   output logic [IW-1:0]  dst_idx,
   output logic [EW-1:0]  dst_dat,
   output logic           fin,
   output logic [LW-1:0]  pack_cnt,
   output logic [MVL-1:0] mask_q,
   output logic [LW-1:0]  vl_q
);

   localparam logic [LW-1:0] MVL_L = LW'(MVL);

   if (MVL < 2 || MVL > 64) begin : g_bad_mvl
      $error("vmask_unit: MVL must lie in 2..64");
   end
   if ((1 << IW) != MVL) begin : g_bad_pow
      $error("vmask_unit: MVL must be a power of two");
   end
   if (EW < 1) begin : g_bad_ew
      $error("vmask_unit: EW must be positive");
   end

   vop_e          op_in, op_q;
   logic          launch;
   logic [IW-1:0] idx;

   assign op_in  = vop_e'(go_op);
   assign el_idx = idx;

   // Vector length register, clamped, frozen while walking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vl_q <= MVL_L;
      else if (vl_we && !busy)
         vl_q <= (vl_din > MVL_L) ? MVL_L : vl_din;
   end

   vmcm_seq #(.MVL(MVL)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (go),
      .go_op  (op_in),
      .vl_q   (vl_q),
      .launch (launch),
      .busy   (busy),
      .idx    (idx),
      .op_q   (op_q),
      .fin    (fin)
   );

   vmcm_mask #(.MVL(MVL), .EW(EW)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .mk_we  (mk_we),
      .mk_din (mk_din),
      .busy   (busy),
      .launch (launch),
      .go_op  (op_in),
      .op_q   (op_q),
      .idx    (idx),
      .src_a  (src_a),
      .src_b  (src_b),
      .mask_q (mask_q)
   );

   vmcm_wb #(.MVL(MVL), .EW(EW), .IDLE_ZERO(IDLE_ZERO)) u_wb (
      .clk     (clk),
      .rst_n   (rst_n),
      .launch  (launch),
      .busy    (busy),
      .op_q    (op_q),
      .idx     (idx),
      .mask_q  (mask_q),
      .res_in  (res_in),
      .dst_we  (dst_we),
      .dst_idx (dst_idx),
      .dst_dat (dst_dat),
      .cnt     (pack_cnt)
   );

endmodule

// File: rtl/vmcm_chk.sv
module vmcm_chk #(
   parameter int MVL = 64,
   parameter int LW  = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           busy,
   input logic           fin,
   input logic           dst_we,
   input logic           mk_we,
   input logic           go,
   input logic [MVL-1:0] mask_q,
   input logic [LW-1:0]  vl_q,
   input logic [LW-1:0]  pack_cnt
);

   // R2
   vl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vl_q));

   // R2
   vl_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vl_q <= LW'(MVL));

   // R3
   mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !mk_we && !go) |=> $stable(mask_q));

   // R5
   we_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> $past(busy));

   // R8
   cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dst_we |-> (pack_cnt != '0));

   // R9
   fin_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> !busy);

   // R10
   start_by_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));

endmodule

bind vmask_unit vmcm_chk #(.MVL(MVL), .LW(LW)) u_chk (.*);

// File: tb/test_vmask_unit.sv
module test_vmask_unit;

   localparam int EW  = 32;
   localparam int MVL = 64;
   localparam int IW  = 6;
   localparam int LW  = 7;
   localparam int NT  = 11;

   // entry: {op[1:0], vl[6:0], sel[7:0]}
   localparam logic [16:0] TBL [0:NT-1] = '{
      {2'd0, 7'd64, 8'h01},
      {2'd0, 7'd10, 8'h02},
      {2'd1, 7'd64, 8'hAA},
      {2'd1, 7'd13, 8'h5C},
      {2'd1, 7'd64, 8'hFF},
      {2'd1, 7'd64, 8'h00},
      {2'd2, 7'd64, 8'hA5},
      {2'd2, 7'd7,  8'hF0},
      {2'd2, 7'd64, 8'hFF},
      {2'd2, 7'd1,  8'h01},
      {2'd0, 7'd1,  8'h00}
   };

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           vl_we = 1'b0;
   logic [LW-1:0]  vl_din = '0;
   logic           mk_we = 1'b0;
   logic [MVL-1:0] mk_din = '0;
   logic           go = 1'b0;
   logic [1:0]     go_op = 2'd0;
   logic           busy;
   logic [IW-1:0]  el_idx;
   logic [EW-1:0]  src_a, src_b, res_in;
   logic           dst_we;
   logic [IW-1:0]  dst_idx;
   logic [EW-1:0]  dst_dat;
   logic           fin;
   logic [LW-1:0]  pack_cnt;
   logic [MVL-1:0] mask_q;
   logic [LW-1:0]  vl_q;

   logic [EW-1:0]  ra [0:MVL-1];
   logic [EW-1:0]  rb [0:MVL-1];
   logic [EW-1:0]  rr [0:MVL-1];
   logic [EW-1:0]  dmem [0:MVL-1];
   logic [EW-1:0]  expd [0:MVL-1];
   logic [MVL-1:0] emask;
   int             ecnt;
   int             n_chk = 0;
   int             n_bad = 0;
   bit             done = 1'b0;

   always #2.5 clk = ~clk;

   always_comb begin
      src_a  = ra[el_idx];
      src_b  = rb[el_idx];
      res_in = rr[el_idx];
   end

   vmask_unit i_vmask_unit (.*);

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fill(input logic [7:0] sel);
      for (int i = 0; i < MVL; i++) begin
         ra[i] = i * 32'h0101_0101 + 32'(sel);
         rb[i] = (((i + int'(sel)) % 3) == 0) ? ra[i] : (ra[i] ^ 32'h80);
         rr[i] = 32'hA000_0000 + 32'(i * 7) + 32'(sel);
      end
   endtask

   task automatic clr_dmem();
      for (int i = 0; i < MVL; i++) dmem[i] = 32'hD000_0000 | 32'(i);
   endtask

   task automatic set_vl(input logic [LW-1:0] v);
      vl_we = 1'b1; vl_din = v;
      @(negedge clk);
      vl_we = 1'b0;
   endtask

   task automatic set_mask(input logic [MVL-1:0] m);
      mk_we = 1'b1; mk_din = m;
      @(negedge clk);
      mk_we = 1'b0;
   endtask

   task automatic run_op(input logic [1:0] op, input bit poke,
                         input bit mk_go, input logic [MVL-1:0] mk_v,
                         input bit vl_go, input logic [LW-1:0] vl_v,
                         output int lat);
      go = 1'b1; go_op = op;
      if (mk_go) begin mk_we = 1'b1; mk_din = mk_v; end
      if (vl_go) begin vl_we = 1'b1; vl_din = vl_v; end
      @(negedge clk);
      go = 1'b0; mk_we = 1'b0; vl_we = 1'b0;
      lat = 1;
      while (1) begin
         if (dst_we) dmem[dst_idx] = dst_dat;
         if (fin) break;
         if (lat > 300) break;
         if (poke && lat == 2) begin
            go = 1'b1; go_op = 2'd0;
            mk_we = 1'b1; mk_din = 64'h0123_4567_89AB_CDEF;
            vl_we = 1'b1; vl_din = 7'd3;
         end else begin
            go = 1'b0; mk_we = 1'b0; vl_we = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      go = 1'b0; mk_we = 1'b0; vl_we = 1'b0;
   endtask

   task automatic model(input logic [1:0] op, input int ev, input logic [MVL-1:0] em);
      ecnt = 0;
      emask = '0;
      for (int i = 0; i < MVL; i++) expd[i] = 32'hD000_0000 | 32'(i);
      for (int i = 0; i < ev; i++) begin
         if (op == 2'd0) emask[i] = (ra[i] == rb[i]);
         else if (em[i]) begin
            if (op == 2'd1) expd[i] = rr[i];
            else            expd[ecnt] = rr[i];
            ecnt++;
         end
      end
   endtask

   task automatic judge(input logic [1:0] op, input int ev, input int lat, input string tag);
      int bad_i;
      bad_i = -1;
      check(lat == ev + 1, {"R9 latency ", tag}, 64'(lat), 64'(ev + 1));
      if (op == 2'd0) begin
         check(mask_q == emask, {"R4 mask ", tag}, mask_q, emask);
      end else begin
         for (int i = MVL - 1; i >= 0; i--) if (dmem[i] !== expd[i]) bad_i = i;
         if (op == 2'd1)
            check(bad_i < 0, {"R5 R6 merge image ", tag},
                  (bad_i < 0) ? 64'd0 : 64'(dmem[bad_i]), (bad_i < 0) ? 64'd0 : 64'(expd[bad_i]));
         else
            check(bad_i < 0, {"R7 R6 compress image ", tag},
                  (bad_i < 0) ? 64'd0 : 64'(dmem[bad_i]), (bad_i < 0) ? 64'd0 : 64'(expd[bad_i]));
         check(int'(pack_cnt) == ecnt, {"R8 count ", tag}, 64'(pack_cnt), 64'(ecnt));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int lat;
      logic [1:0] op;
      logic [LW-1:0] vl;
      logic [7:0] sel;
      logic [MVL-1:0] m;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy == 1'b0 && fin == 1'b0 && dst_we == 1'b0, "R1 idle flags",
            {61'd0, busy, fin, dst_we}, 64'd0);
      check(mask_q == '0, "R1 mask", mask_q, 64'd0);
      check(vl_q == 7'd64, "R1 length", 64'(vl_q), 64'd64);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk
      for (int t = 0; t < NT; t++) begin
         op  = TBL[t][16:15];
         vl  = TBL[t][14:8];
         sel = TBL[t][7:0];
         fill(sel);
         clr_dmem();
         m = (op == 2'd0) ? '1 : {8{sel}};
         set_mask(m);
         set_vl(vl);
         run_op(op, 1'b0, 1'b0, '0, 1'b0, '0, lat);
         model(op, int'(vl), m);
         judge(op, int'(vl), lat, $sformatf("row %0d", t));
      end

      // R2 clamp
      set_vl(7'd100);
      check(vl_q == 7'd64, "R2 clamp", 64'(vl_q), 64'd64);

      // R3 R2 R10: writes and go during a merge are ignored
      fill(8'h33); clr_dmem();
      m = 64'hF0F0_0FF0_1234_8001;
      set_mask(m);
      set_vl(7'd20);
      run_op(2'd1, 1'b1, 1'b0, '0, 1'b0, '0, lat);
      model(2'd1, 20, m);
      judge(2'd1, 20, lat, "busy pokes R10");
      check(mask_q == m, "R3 mask held while busy", mask_q, m);
      check(vl_q == 7'd20, "R2 length held while busy", 64'(vl_q), 64'd20);
      @(negedge clk);
      check(busy == 1'b0, "R10 second go rejected", 64'(busy), 64'd0);

      // R10 op 3 rejected
      go = 1'b1; go_op = 2'd3;
      @(negedge clk);
      go = 1'b0;
      @(negedge clk);
      check(busy == 1'b0 && fin == 1'b0, "R10 op3 ignored", {62'd0, busy, fin}, 64'd0);
      check(mask_q == m, "R10 op3 mask", mask_q, m);

      // R4 compare beats same-cycle scalar mask write
      fill(8'h07);
      set_vl(7'd30);
      run_op(2'd0, 1'b0, 1'b1, '1, 1'b0, '0, lat);
      model(2'd0, 30, '0);
      judge(2'd0, 30, lat, "vs mask write");

      // R3 mask write in merge launch cycle is used by that merge
      fill(8'h11); clr_dmem();
      set_mask(64'hFFFF_FFFF_FFFF_FFFF);
      m = 64'h0000_0000_0055_AA0F;
      run_op(2'd1, 1'b0, 1'b1, m, 1'b0, '0, lat);
      model(2'd1, 30, m);
      judge(2'd1, 30, lat, "R3 launch mask");

      // R2 length write in launch cycle: run uses old length
      fill(8'h22); clr_dmem();
      m = '1;
      set_mask(m);
      run_op(2'd2, 1'b0, 1'b0, '0, 1'b1, 7'd5, lat);
      model(2'd2, 30, m);
      judge(2'd2, 30, lat, "R2 old length");
      check(vl_q == 7'd5, "R2 new length after launch", 64'(vl_q), 64'd5);

      // R11 zero length
      clr_dmem();
      set_vl(7'd0);
      run_op(2'd1, 1'b0, 1'b0, '0, 1'b0, '0, lat);
      model(2'd1, 0, m);
      judge(2'd1, 0, lat, "R11 merge");
      run_op(2'd0, 1'b0, 1'b0, '0, 1'b0, '0, lat);
      check(mask_q == '0, "R11 compare clears mask", mask_q, 64'd0);
      check(lat == 1, "R11 latency", 64'(lat), 64'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule